// File: doc/BRIEF.md
# Byte-Serial 4:2:2 Video Input Port

This block receives a YCbCr 4:2:2 video stream on the input side of a half-duplex expansion port and turns it into whole two-pixel words in a small show-ahead FIFO. The port accepts either a single byte lane carrying samples in turn, or a 16-bit form in which one lane carries luma and the other carries the matching chroma. A byte or beat is taken only on clock edges where the qualifier `din_valid` is high. This lets a gated or qualified source clock drive the port.

Line timing comes from the horizontal reference `href`, and its active edge is chosen by `h_edge_sel`. The active edge opens a line and realigns the chroma phase to Cb. The opposite edge closes the line. The vertical reference `vref` has its own edge select. Its active edge marks a field boundary. At that edge the block latches the field ID from the level of `href`, with `fid_pol` setting the polarity. The requested port direction (`dir_req`) also takes effect only at that boundary. When `code_en` is set, the block writes a start-of-line or end-of-line timing code into the FIFO at the line-opening and line-closing edges. `ready` tells the source that the FIFO still has enough headroom.

The assembler is a state machine with five states. `ST_IDLE` is outside a line or in output mode. `ST_CB`, `ST_Y0`, `ST_CR` and `ST_Y1` each wait for the next sample of a group. In byte mode each valid byte advances the state: CB→Y0→CR→Y1, then back to CB, and the move Y1→CB pushes a word. In 16-bit mode the states are CB→CR, then back to CB, and the move CR→CB pushes a word. An active line edge forces the state to CB. A closing edge, or output mode, forces it to IDLE.

Top module: `vidin_port`

## Requirements
- R1: In byte mode (`wide_mode`=0), valid bytes in the order Cb, Y0, Cr, Y1 produce one FIFO word with Cb in `dout[31:24]`, Y0 in `[23:16]`, Cr in `[15:8]`, Y1 in `[7:0]`, and `dout_code`=0.
- R2: In 16-bit mode, two valid beats form one word. The first beat gives Y0 from `din_y` and Cb from `din_c`. The second beat gives Y1 from `din_y` and Cr from `din_c`. The word uses the same field positions as R1.
- R3: A cycle with `din_valid` low changes no assembly state and pushes nothing.
- R4: The active `href` edge starts a line and resets the phase to Cb, discarding any partial group; the byte in that same cycle is taken as Cb. Bytes on the closing edge cycle or outside a line are ignored.
- R5: With `code_en`=1, the active `href` edge pushes a word `FF 00 00 XY` with H=0, and the closing edge pushes one with H=1. In both cases `dout_code`=1. XY holds bit7=1, bit6=F, bit5=V, bit4=H, bit3=V^H, bit2=F^H, bit1=F^V, bit0=F^V^H.
- R6: With `code_en`=0 no timing word is pushed.
- R7: `h_edge_sel`=0 makes the rising `href` edge active; `h_edge_sel`=1 makes the falling edge active.
- R8: V equals `vref ^ v_edge_sel`. The active `vref` edge is rising for `v_edge_sel`=0 and falling for 1. At that edge, `field_id` becomes `href ^ fid_pol`, and it holds its value at all other times.
- R9: The port direction (1 = input) loads from `dir_req` only on an active `vref` edge; it resets to 0. While it is 0 nothing is accepted and `ready` is low.
- R10: `ready` is high exactly when the direction is input and more than 4 of the 16 FIFO entries are free.
- R11: The FIFO is show-ahead: `dout_valid` shows that it is not empty, `rd_en` pops, order is preserved, and a push into a full FIFO is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_req | input | 1 | Requested direction, 1 = input, applied at a field boundary |
| wide_mode | input | 1 | 1 = 16-bit luma/chroma lanes, 0 = byte-serial |
| code_en | input | 1 | Enables timing-code insertion |
| h_edge_sel | input | 1 | Active `href` edge: 0 rising, 1 falling |
| v_edge_sel | input | 1 | Active `vref` edge: 0 rising, 1 falling |
| fid_pol | input | 1 | Inverts the sampled field ID |
| din_valid | input | 1 | Data qualifier |
| din_y | input | 8 | Byte lane (luma in 16-bit mode) |
| din_c | input | 8 | Chroma lane in 16-bit mode |
| href | input | 1 | Horizontal reference |
| vref | input | 1 | Vertical reference |
| rd_en | input | 1 | Pops the FIFO head |
| ready | output | 1 | Source may send more data |
| dout_valid | output | 1 | FIFO head is valid |
| dout | output | 32 | FIFO head word |
| dout_code | output | 1 | Head word is a timing code |
| field_id | output | 1 | Latched field ID |

## Verification
Suppose the assembler phase slips. Then the next pushed word shows bytes rotated between the Cb, Y and Cr fields, and this is visible at `dout` one cycle after the group's last byte. A wrong direction or field register shows up at `ready` or `field_id` on the cycle after the boundary edge, and it also changes the F or V bits of the next timing code. A wrong FIFO count shows at `ready` when its threshold crossing lands a cycle early or late, and at `dout_valid` when the FIFO is drained. The bench runs a behavioural model and compares these outputs on every clock, so each of these faults appears within a cycle of the stimulus.

// File: rtl/vidin_pkg.sv
package vidin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CB,
        ST_Y0,
        ST_CR,
        ST_Y1
    } asm_state_t;

    // Protected timing byte: marker bit, F, V, H and four parity bits
    function automatic logic [7:0] timing_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/vidin_refs.sv
module vidin_refs (
    input  logic clk,
    input  logic rst_n,
    input  logic href,
    input  logic vref,
    input  logic h_sel,
    input  logic v_sel,
    input  logic fid_pol,
    input  logic dir_req,
    output logic h_start,
    output logic h_end,
    output logic v_bit,
    output logic field_id,
    output logic dir_in
);
    logic href_q, vref_q, field_q, dir_q;
    logic h_rise, h_fall, v_rise, v_fall, v_start;

    assign h_rise  = href & ~href_q;
    assign h_fall  = ~href & href_q;
    assign v_rise  = vref & ~vref_q;
    assign v_fall  = ~vref & vref_q;
    assign h_start = h_sel ? h_fall : h_rise;
    assign h_end   = h_sel ? h_rise : h_fall;
    assign v_start = v_sel ? v_fall : v_rise;
    assign v_bit   = vref ^ v_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            href_q  <= 1'b0;
            vref_q  <= 1'b0;
            field_q <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            href_q <= href;
            vref_q <= vref;
            if (v_start) begin
                field_q <= href ^ fid_pol;
                dir_q   <= dir_req;
            end
        end
    end

    assign field_id = field_q;
    assign dir_in   = dir_q;

    // R9: direction only moves at a field boundary
    assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !v_start |=> dir_q == $past(dir_q));

    // R8: field ID only moves at a field boundary
    assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !v_start |=> field_q == $past(field_q));

endmodule

// File: rtl/vidin_asm.sv
module vidin_asm
    import vidin_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_in,
    input  logic          wide,
    input  logic          valid,
    input  logic [DW-1:0] dy,
    input  logic [DW-1:0] dc,
    input  logic          h_start,
    input  logic          h_end,
    input  logic          code_en,
    input  logic          field_id,
    input  logic          v_bit,
    output logic          push,
    output logic          push_code,
    output logic [4*DW-1:0] push_word
);
    asm_state_t state_q, cur, nxt;
    logic [DW-1:0] cb_q, y0_q, cr_q;
    logic [DW-1:0] cb_d, y0_d, cr_d;
    logic data_push, code_push;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Held samples of the group in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb_q <= '0;
            y0_q <= '0;
            cr_q <= '0;
        end else begin
            cb_q <= cb_d;
            y0_q <= y0_d;
            cr_q <= cr_d;
        end
    end

    // Next state and outputs
    always_comb begin
        cur       = h_start ? ST_CB : (h_end ? ST_IDLE : state_q);
        nxt       = cur;
        cb_d      = cb_q;
        y0_d      = y0_q;
        cr_d      = cr_q;
        data_push = 1'b0;
        code_push = 1'b0;
        push_word = '0;
        if (!dir_in) begin
            nxt = ST_IDLE;
        end else begin
            if ((h_start || h_end) && code_en) begin
                code_push = 1'b1;
                push_word = {{DW{1'b1}}, {(2*DW){1'b0}}, DW'(timing_xy(field_id, v_bit, h_end))};
            end
            if (valid) begin
                unique case (cur)
                    ST_IDLE: nxt = ST_IDLE;
                    ST_CB: begin
                        if (wide) begin
                            cb_d = dc;
                            y0_d = dy;
                            nxt  = ST_CR;
                        end else begin
                            cb_d = dy;
                            nxt  = ST_Y0;
                        end
                    end
                    ST_Y0: begin
                        y0_d = dy;
                        nxt  = ST_CR;
                    end
                    ST_CR: begin
                        if (wide) begin
                            data_push = 1'b1;
                            push_word = {cb_q, y0_q, dc, dy};
                            nxt       = ST_CB;
                        end else begin
                            cr_d = dy;
                            nxt  = ST_Y1;
                        end
                    end
                    ST_Y1: begin
                        data_push = 1'b1;
                        push_word = {cb_q, y0_q, cr_q, dy};
                        nxt       = ST_CB;
                    end
                    default: nxt = ST_IDLE;
                endcase
            end
        end
        push      = code_push | data_push;
        push_code = code_push;
    end

    // R5: a timing code and a pixel word never compete for the same cycle
    assert_one_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_push && data_push));

    // R9: output mode leaves the assembler idle
    assert_idle_when_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_in |=> state_q == ST_IDLE);

endmodule

// File: rtl/vidin_fifo.sv
module vidin_fifo #(
    parameter int W        = 33,
    parameter int DEPTH    = 16,
    parameter int FREE_MIN = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         room,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int LIMIT = DEPTH - FREE_MIN;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_q;
    logic full, do_push, do_pop;

    assign full    = (count_q == CW'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign room  = (count_q < CW'(LIMIT));
    assign count = count_q;

    // R11: occupancy never passes the depth
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R11: a push into a full FIFO without a pop leaves it unchanged
    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> count_q == $past(count_q));

endmodule

// File: rtl/vidin_port.sv
module vidin_port #(
    parameter int DW       = 8,
    parameter int DEPTH    = 16,
    parameter int FREE_MIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dir_req,
    input  logic            wide_mode,
    input  logic            code_en,
    input  logic            h_edge_sel,
    input  logic            v_edge_sel,
    input  logic            fid_pol,
    input  logic            din_valid,
    input  logic [DW-1:0]   din_y,
    input  logic [DW-1:0]   din_c,
    input  logic            href,
    input  logic            vref,
    input  logic            rd_en,
    output logic            ready,
    output logic            dout_valid,
    output logic [4*DW-1:0] dout,
    output logic            dout_code,
    output logic            field_id
);
    localparam int WORD_W = 4 * DW;
    localparam int ENT_W  = WORD_W + 1;
    localparam int CW     = $clog2(DEPTH + 1);

    logic h_start, h_end, v_bit, dir_in;
    logic push, push_code;
    logic [WORD_W-1:0] push_word;
    logic [ENT_W-1:0]  head;
    logic fifo_empty, fifo_room;
    logic [CW-1:0] fifo_count;

    vidin_refs u_refs (
        .clk      (clk),
        .rst_n    (rst_n),
        .href     (href),
        .vref     (vref),
        .h_sel    (h_edge_sel),
        .v_sel    (v_edge_sel),
        .fid_pol  (fid_pol),
        .dir_req  (dir_req),
        .h_start  (h_start),
        .h_end    (h_end),
        .v_bit    (v_bit),
        .field_id (field_id),
        .dir_in   (dir_in)
    );

    vidin_asm #(.DW(DW)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_in    (dir_in),
        .wide      (wide_mode),
        .valid     (din_valid),
        .dy        (din_y),
        .dc        (din_c),
        .h_start   (h_start),
        .h_end     (h_end),
        .code_en   (code_en),
        .field_id  (field_id),
        .v_bit     (v_bit),
        .push      (push),
        .push_code (push_code),
        .push_word (push_word)
    );

    vidin_fifo #(.W(ENT_W), .DEPTH(DEPTH), .FREE_MIN(FREE_MIN)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({push_code, push_word}),
        .pop   (rd_en),
        .rdata (head),
        .empty (fifo_empty),
        .room  (fifo_room),
        .count (fifo_count)
    );

    assign ready      = dir_in && fifo_room;
    assign dout_valid = !fifo_empty;
    assign dout       = head[WORD_W-1:0];
    assign dout_code  = head[WORD_W];

    // R10: once ready is shown, the next cycle cannot find the FIFO full
    assert_ready_headroom_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> fifo_count < CW'(DEPTH));

endmodule

// File: tb/tb_vidin_port.sv
`timescale 1ns/1ps
module tb_vidin_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_req = 0, wide_mode = 0, code_en = 0;
    logic h_edge_sel = 0, v_edge_sel = 0, fid_pol = 0;
    logic din_valid = 0;
    logic [7:0] din_y = 0, din_c = 0;
    logic href = 0, vref = 0, rd_en = 0;
    logic ready, dout_valid, dout_code, field_id;
    logic [31:0] dout;

    always #10 clk = ~clk;

    vidin_port dut (
        .clk(clk), .rst_n(rst_n), .dir_req(dir_req), .wide_mode(wide_mode),
        .code_en(code_en), .h_edge_sel(h_edge_sel), .v_edge_sel(v_edge_sel),
        .fid_pol(fid_pol), .din_valid(din_valid), .din_y(din_y), .din_c(din_c),
        .href(href), .vref(vref), .rd_en(rd_en), .ready(ready),
        .dout_valid(dout_valid), .dout(dout), .dout_code(dout_code),
        .field_id(field_id)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    string cur_req = "R9";

    // Behavioural reference model
    logic [32:0] mq[$];
    bit m_dir, m_field, m_hp, m_vp;
    int m_phase;
    logic [7:0] m_cb, m_y0, m_cr;
    bit m_hst, m_hen, m_vst, m_push;
    logic [32:0] m_ent;
    int m_sz;

    function automatic logic [32:0] code_ent(bit f, bit v, bit h);
        logic [7:0] xy;
        xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        return {1'b1, 8'hFF, 8'h00, 8'h00, xy};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_dir = 0; m_field = 0; m_hp = 0; m_vp = 0; m_phase = -1;
            m_cb = 0; m_y0 = 0; m_cr = 0;
        end else begin
            m_hst  = h_edge_sel ? (m_hp && !href) : (!m_hp && href);
            m_hen  = h_edge_sel ? (!m_hp && href) : (m_hp && !href);
            m_vst  = v_edge_sel ? (m_vp && !vref) : (!m_vp && vref);
            m_push = 0;
            m_ent  = '0;
            if (m_dir) begin
                if (m_hst) begin
                    m_phase = 0;
                    if (code_en) begin m_push = 1; m_ent = code_ent(m_field, vref ^ v_edge_sel, 0); end
                end else if (m_hen) begin
                    m_phase = -1;
                    if (code_en) begin m_push = 1; m_ent = code_ent(m_field, vref ^ v_edge_sel, 1); end
                end
                if (m_phase >= 0 && din_valid) begin
                    case (m_phase)
                        0: if (wide_mode) begin m_cb = din_c; m_y0 = din_y; m_phase = 2; end
                           else begin m_cb = din_y; m_phase = 1; end
                        1: begin m_y0 = din_y; m_phase = 2; end
                        2: if (wide_mode) begin m_push = 1; m_ent = {1'b0, m_cb, m_y0, din_c, din_y}; m_phase = 0; end
                           else begin m_cr = din_y; m_phase = 3; end
                        default: begin m_push = 1; m_ent = {1'b0, m_cb, m_y0, m_cr, din_y}; m_phase = 0; end
                    endcase
                end
            end else begin
                m_phase = -1;
            end
            m_sz = mq.size();
            if (rd_en && m_sz > 0) void'(mq.pop_front());
            if (m_push && m_sz < 16) mq.push_back(m_ent);
            if (m_vst) begin
                m_field = href ^ fid_pol;
                m_dir   = dir_req;
            end
            m_hp = href;
            m_vp = vref;
        end
    end

    task automatic cmp(input string tag, input string what, input logic [32:0] act, input logic [32:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp(cur_req, "ready", {32'd0, ready}, {32'd0, (m_dir && mq.size() < 12)});
            cmp(cur_req, "dout_valid", {32'd0, dout_valid}, {32'd0, (mq.size() > 0)});
            cmp(cur_req, "field_id", {32'd0, field_id}, {32'd0, m_field});
            if (mq.size() > 0) cmp(cur_req, "head", {dout_code, dout}, mq[0]);
        end
    end

    task automatic nxt();
        @(negedge clk);
        #2;
    endtask

    task automatic put(input logic v, input logic [7:0] y, input logic [7:0] c);
        nxt();
        din_valid = v; din_y = y; din_c = c; rd_en = 0;
    endtask

    task automatic pop1();
        put(0, 8'hEE, 8'hEE);
        rd_en = 1;
        put(0, 0, 0);
    endtask

    task automatic drain_all();
        int guard = 0;
        while (dout_valid && guard < 40) begin
            pop1();
            guard++;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog expired actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) nxt();
        rst_n = 1;
        nxt();
        // R9: reset state is output mode with an empty FIFO
        cur_req = "R9";
        cmp("R9", "reset ready", {32'd0, ready}, 33'd0);
        cmp("R11", "reset dout_valid", {32'd0, dout_valid}, 33'd0);
        cmp("R8", "reset field_id", {32'd0, field_id}, 33'd0);

        // R9: a request alone does not switch direction
        dir_req = 1;
        put(0, 0, 0); put(0, 0, 0);
        cmp("R9", "ready before boundary", {32'd0, ready}, 33'd0);
        vref = 1;                         // rising edge = active, href low
        put(0, 0, 0); vref = 0;
        put(0, 0, 0);
        cmp("R10", "ready after boundary", {32'd0, ready}, 33'd1);

        // R1, R3: byte mode with a gap
        cur_req = "R1";
        put(1, 8'h10, 0); href = 1;
        put(1, 8'h20, 0);
        put(0, 8'hEE, 0);                 // R3: not qualified
        put(1, 8'h30, 0);
        put(1, 8'h40, 0);
        put(0, 0, 0);
        cmp("R1", "byte group", {dout_code, dout}, {1'b0, 32'h10203040});
        pop1();
        cmp("R11", "empty after pop", {32'd0, dout_valid}, 33'd0);

        // R4: partial group dropped, bytes outside a line ignored
        cur_req = "R4";
        put(1, 8'h55, 0);
        put(1, 8'h66, 0);
        put(0, 0, 0); href = 0;           // closing edge
        put(1, 8'h99, 0);                 // outside a line
        put(1, 8'hA0, 0); href = 1;       // new line: Cb
        put(1, 8'hA1, 0);
        put(1, 8'hA2, 0);
        put(1, 8'hA3, 0);
        put(0, 0, 0);
        cmp("R4", "realigned group", {dout_code, dout}, {1'b0, 32'hA0A1A2A3});
        pop1();

        // R5: timing codes at both edges
        cur_req = "R5";
        code_en = 1;
        put(0, 0, 0); href = 0;
        put(0, 0, 0);
        put(0, 0, 0); href = 1;
        put(0, 0, 0);
        put(0, 0, 0);
        cmp("R5", "end code", {dout_code, dout}, {1'b1, 32'hFF00009D});
        pop1();
        cmp("R5", "start code", {dout_code, dout}, {1'b1, 32'hFF000080});
        pop1();

        // R6: codes off
        cur_req = "R6";
        code_en = 0;
        put(0, 0, 0); href = 0;
        put(0, 0, 0); href = 1;
        put(0, 0, 0);
        put(0, 0, 0);
        cmp("R6", "no code pushed", {32'd0, dout_valid}, 33'd0);

        // R2: 16-bit lanes
        cur_req = "R2";
        wide_mode = 1;
        put(1, 8'h11, 8'hA1);
        put(1, 8'h22, 8'hB1);
        put(0, 0, 0);
        cmp("R2", "wide group", {dout_code, dout}, {1'b0, 32'hA111B122});
        pop1();

        // R7: falling edge as active
        cur_req = "R7";
        wide_mode = 0; code_en = 1; h_edge_sel = 1;
        put(0, 0, 0);
        put(1, 8'hC0, 0); href = 0;
        put(1, 8'hC1, 0);
        put(1, 8'hC2, 0);
        put(1, 8'hC3, 0);
        put(0, 0, 0); href = 1;
        put(0, 0, 0);
        cmp("R7", "start code on fall", {dout_code, dout}, {1'b1, 32'hFF000080});
        pop1();
        cmp("R7", "group after fall", {dout_code, dout}, {1'b0, 32'hC0C1C2C3});
        pop1();
        cmp("R7", "end code on rise", {dout_code, dout}, {1'b1, 32'hFF00009D});
        pop1();

        // R8: falling vref edge, field sampled from href
        cur_req = "R8";
        v_edge_sel = 1; fid_pol = 0;
        put(0, 0, 0); vref = 1;
        put(0, 0, 0); vref = 0;           // active edge with href high
        put(0, 0, 0);
        cmp("R8", "field_id", {32'd0, field_id}, 33'd1);
        href = 0;                         // line start, V = 0^1 = 1
        put(0, 0, 0);
        put(0, 0, 0);
        cmp("R5", "code F=1 V=1", {dout_code, dout}, {1'b1, 32'hFF0000EC});
        drain_all();

        // R9: direction change waits for the boundary
        cur_req = "R9";
        code_en = 0; dir_req = 0;
        put(1, 8'h01, 0);
        put(1, 8'h02, 0);
        put(1, 8'h03, 0);
        put(1, 8'h04, 0);
        put(0, 0, 0);
        cmp("R9", "still accepting", {dout_code, dout}, {1'b0, 32'h01020304});
        drain_all();
        put(0, 0, 0); vref = 1;
        put(0, 0, 0); vref = 0;
        put(0, 0, 0);
        put(0, 0, 0);
        cmp("R9", "ready in output mode", {32'd0, ready}, 33'd0);
        put(1, 8'h71, 0); href = 1;
        put(1, 8'h72, 0); href = 0;
        put(1, 8'h73, 0);
        put(1, 8'h74, 0);
        put(1, 8'h75, 0);
        put(1, 8'h76, 0);
        put(0, 0, 0);
        cmp("R9", "nothing accepted", {32'd0, dout_valid}, 33'd0);
        dir_req = 1;
        put(0, 0, 0); vref = 1;
        put(0, 0, 0); vref = 0;
        put(0, 0, 0);
        put(0, 0, 0);
        cmp("R9", "input mode again", {32'd0, ready}, 33'd1);

        // R10, R11: fill past the threshold and past the depth
        cur_req = "R10";
        h_edge_sel = 0;
        put(0, 0, 0);
        for (int g = 0; g < 20; g++) begin
            for (int k = 0; k < 4; k++) begin
                put(1, 8'(g * 4 + k), 0);
                if (g == 0 && k == 0) href = 1;
            end
        end
        put(0, 0, 0);
        put(0, 0, 0);
        cmp("R10", "ready low when full", {32'd0, ready}, 33'd0);
        cur_req = "R11";
        cmp("R11", "oldest word first", {dout_code, dout}, {1'b0, 32'h00010203});
        drain_all();
        cmp("R11", "drained", {32'd0, dout_valid}, 33'd0);
        cmp("R10", "ready after drain", {32'd0, ready}, 33'd1);

        put(0, 0, 0);
        done = 1;
        summary();
        $finish;
    end

endmodule